// File: doc/BRIEF.md
# I2C Interrupt Vector Encoder

This block sits next to an I2C controller core and collects the core's one-cycle event pulses into sticky pending bits. An enable mask selects which of those events may raise the interrupt request. A vector register reports the single pending enabled event with the best priority as a 3-bit code. Software services the controller by reading the vector register over and over. Each read returns one cause, and the read itself retires that cause, so the following read returns the next one. A code of zero ends the service pass.

Software clears events in one of three ways. Reading the vector clears the event it reports. Writing ones to the status register clears the control events. The two data-ready events are different: they clear only when the controller's data path is used. That means a read of the receive data register, or a write to the transmit data register, which the neighbouring logic signals as a one-cycle pulse. Register reads are combinational, so data is valid in the same cycle that the read strobe is high. Side effects of a read take place at the clock edge that ends that cycle.

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset, all pending bits and all mask bits are 0, the vector reads 0, and `irq` is low.
- R2: A pulse on `evt_pulse[i]` sets pending bit i, and the bit stays set until it is cleared. The setting happens whether or not the event is enabled. Event indices are: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave. The status register (address 1) shows pending bit i at bit i.
- R3: Status bit 11 shows the live level of `rsfull_in`. Status bit 12 shows the live level of `busy_in`. All other status bits above 6 read 0.
- R4: The vector register (address 2) reads i+1 for the lowest index i that is both pending and enabled. If there is no such index, it reads 0. The codes are: 1 arbitration lost, 2 NACK, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed as slave.
- R5: `irq` is high exactly when at least one pending bit is also enabled.
- R6: A read of the vector register clears the pending bit of the event it reports, unless the code is 4 or 5. A read that returns 4 or 5 leaves the pending bits unchanged.
- R7: A write to the status register clears each pending bit 0, 1, 2, 5 or 6 whose write-data bit is 1. Bits 3 and 4 are not affected by status writes.
- R8: A pulse on `rx_data_rd` clears receive ready (bit 3). A pulse on `tx_data_wr` clears transmit ready (bit 4).
- R9: If an event pulse arrives in the same cycle as any clear of its bit, the bit stays set.
- R10: The mask register (address 0) is read/write in bits 6:0, with bit i enabling event i. Mask bits above 6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 7 | One-cycle event pulses from the controller core |
| rsfull_in | input | 1 | Receive shift register full level |
| busy_in | input | 1 | Bus busy level |
| rx_data_rd | input | 1 | Pulse: receive data register was read |
| tx_data_wr | input | 1 | Pulse: transmit data register was written |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register address: 0 mask, 1 status, 2 vector |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 16-bit data path, a 2-bit address, and the address map and flag positions from the requirements. This places both live flags at bits 11 and 12 inside the word, so they can be seen next to the seven sticky bits. With all seven events enabled, the bench can walk a complete drain sequence of codes 1, 2, 3, 6, 7 and then 0. Partial masks show that a disabled event with a better priority is skipped. Event pulses are driven in the same cycle as each of the three kinds of clear, which shows that a set wins over a clear.

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector #(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 2,
  parameter int MASK_ADDR  = 0,
  parameter int STAT_ADDR  = 1,
  parameter int VEC_ADDR   = 2,
  parameter int RSFULL_BIT = 11,
  parameter int BUSY_BIT   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        evt_pulse,
  input  logic              rsfull_in,
  input  logic              busy_in,
  input  logic              rx_data_rd,
  input  logic              tx_data_wr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int NEVT  = 7;
  localparam int VEC_W = $clog2(NEVT + 1);
  localparam logic [NEVT-1:0] DATA_BITS = 7'b0011000;
  localparam logic [NEVT-1:0] W1C_BITS  = ~DATA_BITS;

  logic [NEVT-1:0]  pend, mask_q, masked, clr_rd, clr_w1c, clr_dat;
  logic [VEC_W-1:0] vec;
  logic             rd_vec, wr_mask, wr_stat;

  assign masked  = pend & mask_q;
  assign irq     = |masked;
  assign rd_vec  = reg_rd && reg_addr == ADDR_W'(VEC_ADDR);
  assign wr_mask = reg_wr && reg_addr == ADDR_W'(MASK_ADDR);
  assign wr_stat = reg_wr && reg_addr == ADDR_W'(STAT_ADDR);

  always_comb begin
    vec = '0;
    for (int i = NEVT - 1; i >= 0; i--)
      if (masked[i]) vec = VEC_W'(i + 1);
  end

  always_comb begin
    clr_rd = '0;
    if (rd_vec && vec != '0) clr_rd[vec - VEC_W'(1)] = 1'b1;
    clr_rd &= W1C_BITS;
  end

  assign clr_w1c = wr_stat ? (reg_wdata[NEVT-1:0] & W1C_BITS) : '0;
  assign clr_dat = {2'b00, tx_data_wr, rx_data_rd, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend   <= '0;
      mask_q <= '0;
    end else begin
      pend <= (pend & ~(clr_rd | clr_w1c | clr_dat)) | evt_pulse;
      if (wr_mask) mask_q <= reg_wdata[NEVT-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(MASK_ADDR)) begin
      reg_rdata[NEVT-1:0] = mask_q;
    end else if (reg_addr == ADDR_W'(STAT_ADDR)) begin
      reg_rdata[NEVT-1:0]  = pend;
      reg_rdata[RSFULL_BIT] = rsfull_in;
      reg_rdata[BUSY_BIT]   = busy_in;
    end else if (reg_addr == ADDR_W'(VEC_ADDR)) begin
      reg_rdata[VEC_W-1:0] = vec;
    end
  end

  p_sticky_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse[0] |=> pend[0]);

  p_irq_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> vec != '0);

  p_vec_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec != '0 |-> mask_q[vec - VEC_W'(1)] && pend[vec - VEC_W'(1)]);

  p_read_retires_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vec && vec == VEC_W'(1) && !evt_pulse[0]) |=> !pend[0]);

  p_xrdy_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[4] && !tx_data_wr) |=> pend[4]);

  p_rrdy_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[3] && !rx_data_rd) |=> pend[3]);
endmodule

// File: tb/i2c_irq_vector_test.sv
module i2c_irq_vector_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  evt_pulse = '0;
  logic        rsfull_in = 0, busy_in = 0, rx_data_rd = 0, tx_data_wr = 0;
  logic        reg_wr = 0, reg_rd = 0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int checks = 0, failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          done = 0;

  always #5 clk = ~clk;

  i2c_irq_vector uut (.clk, .rst_n, .evt_pulse, .rsfull_in, .busy_in,
    .rx_data_rd, .tx_data_wr, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .irq);

  always @(negedge clk) begin
    if (reg_rd) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL unexpected read: actual %h expected none", reg_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          failures++;
          $display("FAIL %s: actual %h expected %h", t, reg_rdata, e);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string t);
    reg_rd = 1; reg_addr = a; exp_q.push_back(e); tag_q.push_back(t);
    step();
    reg_rd = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic pulse(input logic [6:0] e);
    evt_pulse = e;
    step();
    evt_pulse = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
    step();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R1 reset state
    rd(0, 16'h0000, "R1 mask");
    rd(1, 16'h0000, "R1 status");
    rd(2, 16'h0000, "R1 vector");
    chk_irq(0, "R1 irq");
    // R3 live flags
    rsfull_in = 1; rd(1, 16'h0800, "R3 rsfull");
    busy_in = 1;   rd(1, 16'h1800, "R3 busy");
    rsfull_in = 0; busy_in = 0;
    // R2 sticky while disabled, R5 no irq
    pulse(7'h01);
    rd(1, 16'h0001, "R2 sticky disabled");
    rd(2, 16'h0000, "R4 disabled hidden");
    chk_irq(0, "R5 masked off");
    // R10 mask
    wr(0, 16'hFFFF);
    rd(0, 16'h007F, "R10 mask upper zero");
    chk_irq(1, "R5 enabled");
    // R6 drain order
    pulse(7'h66);
    rd(1, 16'h0067, "R2 all set");
    rd(2, 16'd1, "R6 code1");
    rd(2, 16'd2, "R6 code2");
    rd(2, 16'd3, "R6 code3");
    rd(2, 16'd6, "R6 code6");
    rd(2, 16'd7, "R6 code7");
    rd(2, 16'd0, "R6 drained");
    chk_irq(0, "R5 drained");
    // R8 data-ready events
    pulse(7'h18);
    rd(2, 16'd4, "R4 code4");
    rd(2, 16'd4, "R6 code4 kept");
    rx_data_rd = 1; step(); rx_data_rd = 0;
    rd(2, 16'd5, "R8 rrdy cleared");
    rd(2, 16'd5, "R6 code5 kept");
    tx_data_wr = 1; step(); tx_data_wr = 0;
    rd(2, 16'd0, "R8 xrdy cleared");
    // R7 write-one-to-clear
    pulse(7'h18);
    wr(1, 16'h0018);
    rd(1, 16'h0018, "R7 data bits immune");
    pulse(7'h25);
    wr(1, 16'h0024);
    rd(1, 16'h0019, "R7 w1c");
    rx_data_rd = 1; tx_data_wr = 1; step(); rx_data_rd = 0; tx_data_wr = 0;
    wr(1, 16'h007F);
    rd(1, 16'h0000, "R7 all clear");
    // R4 priority with partial mask
    wr(0, 16'h0020);
    pulse(7'h21);
    rd(2, 16'd6, "R4 skip disabled");
    rd(2, 16'd0, "R4 none enabled");
    chk_irq(0, "R5 partial mask");
    rd(1, 16'h0001, "R6 disabled kept");
    // R9 set wins over clear
    wr(0, 16'h007F);
    evt_pulse = 7'h01; reg_wr = 1; reg_addr = 1; reg_wdata = 16'h0001;
    step(); evt_pulse = '0; reg_wr = 0;
    rd(1, 16'h0001, "R9 w1c vs set");
    evt_pulse = 7'h01; rd(2, 16'd1, "R9 read vs set");
    evt_pulse = '0;
    rd(2, 16'd1, "R9 kept after read");
    evt_pulse = 7'h08; rx_data_rd = 1; step(); evt_pulse = '0; rx_data_rd = 0;
    rd(1, 16'h0008, "R9 data vs set");
    step();
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule